// File: doc/BRIEF.md
# Two-Wire Bus Timing Compliance Monitor

This block sits passively on the clock line (SCL) and data line (SDA) of a 400 kHz two-wire serial bus. It never drives the bus. Both lines are synchronised to a fast system clock and cleaned of short glitches. START and STOP conditions are recognised on the cleaned lines. Every interval that has a fast-mode minimum is then counted in system-clock cycles.

When an interval ends too early, the matching violation bit is set and stays set until software-independent logic pulses the clear input. A one-cycle event strobe reports the broken rule as a 3-bit code. The minimum durations are given in nanoseconds, together with the clock period, and are turned into cycle counts at elaboration.

Top module: `i2c_timing_monitor`

## Requirements
- R1: Each line passes through a two-stage synchroniser and a glitch filter. The filter adopts a new level only after it has been seen on `FILT_CYC` consecutive cycles. With the defaults (20 ns clock, 50 ns spike limit), `FILT_CYC` is 3, so a 2-cycle pulse is ignored and a 3-cycle pulse is accepted. Both filtered outputs reset to 1.
- R2: `start_o` pulses for one cycle when filtered SDA falls while filtered SCL is high in both the previous and the current cycle.
- R3: `stop_o` pulses for one cycle when filtered SDA rises while filtered SCL is high in both the previous and the current cycle.
- R4: If SCL rises less than 1300 ns (65 cycles) after it fell, rule code 0 (clock low) is flagged.
- R5: If SCL falls less than 600 ns (30 cycles) after it rose, rule code 1 (clock high) is flagged. An interval of exactly 30 cycles passes.
- R6: If a START comes less than 1300 ns after the previous STOP, rule code 2 (bus free) is flagged.
- R7: If a START comes less than 600 ns after the last SCL rise, rule code 3 (start setup) is flagged. This covers repeated STARTs.
- R8: If SCL falls less than 600 ns after a START, rule code 4 (start hold) is flagged.
- R9: If SCL rises less than 100 ns (5 cycles) after the last SDA edge, rule code 5 (data setup) is flagged.
- R10: If a STOP comes less than 600 ns after the last SCL rise, rule code 6 (stop setup) is flagged.
- R11: `viol_o[k]` is set for rule code k and stays set until a one-cycle `clr_i`. A clear removes all earlier bits, but a violation detected in the same cycle as the clear is kept.
- R12: Each violation produces a one-cycle `evt_o` with `evt_code_o` equal to the rule code. If several rules trip in the same cycle, the lowest code is reported.
- R13: The interval counters saturate instead of wrapping. A long idle bus followed by a compliant transfer therefore raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| clr_i | input | 1 | One-cycle pulse that clears sticky violation bits |
| scl_o | output | 1 | Filtered clock line |
| sda_o | output | 1 | Filtered data line |
| start_o | output | 1 | START condition strobe |
| stop_o | output | 1 | STOP condition strobe |
| viol_o | output | 7 | Sticky violation bits, indexed by rule code |
| evt_o | output | 1 | One-cycle violation event |
| evt_code_o | output | 3 | Rule code of the reported event |

## Verification
The hardest cases to reach are the exact-threshold ones. An SCL high phase of exactly the minimum must pass, while one cycle less must fail. A glitch one cycle shorter than the filter's acceptance length must leave no trace. The synchroniser and the filter add a fixed delay to both lines, so the bench drives the raw lines with cycle-exact waits and the measured intervals equal the driven ones. It also builds frames in which only one interval is shortened, so that each rule code appears alone, in a known order, for the scoreboard queue.

// File: rtl/i2c_tmon_pkg.sv
package i2c_tmon_pkg;
  localparam int unsigned NUM_RULES = 7;

  typedef enum logic [2:0] {
    RULE_SCL_LOW  = 3'd0,
    RULE_SCL_HIGH = 3'd1,
    RULE_BUS_FREE = 3'd2,
    RULE_STA_SU   = 3'd3,
    RULE_STA_HD   = 3'd4,
    RULE_DAT_SU   = 3'd5,
    RULE_STO_SU   = 3'd6
  } rule_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/i2c_tmon_filter.sv
module i2c_tmon_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   out_q;
  logic                   raw;

  assign raw    = sync_q[SYNC_STAGES-1];
  assign line_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // adopt a new level only after FILT_CYC consecutive agreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else if (raw == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      out_q <= raw;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(raw) == line_o)); // R1
endmodule

// File: rtl/i2c_tmon_cond.sv
module i2c_tmon_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_edge_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign sda_edge_o = sda_i ^ sda_q;
  // SCL must be high on both sides of the SDA edge
  assign start_o    = ~sda_i & sda_q & scl_i & scl_q;
  assign stop_o     = sda_i & ~sda_q & scl_i & scl_q;
endmodule

// File: rtl/i2c_tmon_check.sv
module i2c_tmon_check
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned LOW_CYC    = 65,
  parameter int unsigned HIGH_CYC   = 30,
  parameter int unsigned BUF_CYC    = 65,
  parameter int unsigned STA_SU_CYC = 30,
  parameter int unsigned STA_HD_CYC = 30,
  parameter int unsigned DAT_SU_CYC = 5,
  parameter int unsigned STO_SU_CYC = 30
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 sda_edge_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 clr_i,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 evt_o,
  output logic [2:0]           evt_code_o
);
  localparam int unsigned TMAX = max2(max2(max2(LOW_CYC, HIGH_CYC), max2(BUF_CYC, STA_SU_CYC)),
                                      max2(max2(STA_HD_CYC, DAT_SU_CYC), STO_SU_CYC));
  localparam int unsigned CNT_W = $clog2(TMAX + 1) + 1;
  localparam int unsigned NCNT  = 3;
  localparam logic [CNT_W-1:0] SAT = '1;

  localparam logic [CNT_W-1:0] L_LOW    = CNT_W'(LOW_CYC);
  localparam logic [CNT_W-1:0] L_HIGH   = CNT_W'(HIGH_CYC);
  localparam logic [CNT_W-1:0] L_BUF    = CNT_W'(BUF_CYC);
  localparam logic [CNT_W-1:0] L_STA_SU = CNT_W'(STA_SU_CYC);
  localparam logic [CNT_W-1:0] L_STA_HD = CNT_W'(STA_HD_CYC);
  localparam logic [CNT_W-1:0] L_DAT_SU = CNT_W'(DAT_SU_CYC);
  localparam logic [CNT_W-1:0] L_STO_SU = CNT_W'(STO_SU_CYC);

  // counter 0: since SCL edge, 1: since SDA edge, 2: since STOP
  logic [NCNT-1:0]  restart;
  logic [CNT_W-1:0] cnt [NCNT];

  assign restart = {stop_i, sda_edge_i, scl_rise_i | scl_fall_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= SAT;
      else if (restart[g]) q <= CNT_W'(1);
      else if (q != SAT)   q <= q + 1'b1;
    end
    assign cnt[g] = q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q != '0); // R13
  end

  logic hold_arm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_arm_q <= 1'b0;
    else if (start_i)             hold_arm_q <= 1'b1;
    else if (scl_fall_i | stop_i) hold_arm_q <= 1'b0;
  end

  logic [NUM_RULES-1:0] hit;
  always_comb begin
    hit                = '0;
    hit[RULE_SCL_LOW]  = scl_rise_i & (cnt[0] < L_LOW);
    hit[RULE_SCL_HIGH] = scl_fall_i & (cnt[0] < L_HIGH);
    hit[RULE_BUS_FREE] = start_i & (cnt[2] < L_BUF);
    hit[RULE_STA_SU]   = start_i & (cnt[0] < L_STA_SU);
    hit[RULE_STA_HD]   = scl_fall_i & hold_arm_q & (cnt[1] < L_STA_HD);
    hit[RULE_DAT_SU]   = scl_rise_i & (cnt[1] < L_DAT_SU);
    hit[RULE_STO_SU]   = stop_i & (cnt[0] < L_STO_SU);
  end

  logic [2:0] first_code;
  always_comb begin
    first_code = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit[i]) first_code = 3'(i);
    end
  end

  logic [NUM_RULES-1:0] viol_q;
  logic                 evt_q;
  logic [2:0]           code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= '0;
      evt_q  <= 1'b0;
      code_q <= '0;
    end else begin
      viol_q <= clr_i ? hit : (viol_q | hit);
      evt_q  <= |hit;
      code_q <= first_code;
    end
  end

  assign viol_o     = viol_q;
  assign evt_o      = evt_q;
  assign evt_code_o = code_q;

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ((viol_o & $past(viol_o)) == $past(viol_o))); // R11
  AST_EVT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> viol_o[evt_code_o]); // R12
  AST_HOLD_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> hold_arm_q); // R8
endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SPIKE_NS      = 50,
  parameter int unsigned LOW_NS        = 1300,
  parameter int unsigned HIGH_NS       = 600,
  parameter int unsigned BUF_NS        = 1300,
  parameter int unsigned STA_SU_NS     = 600,
  parameter int unsigned STA_HD_NS     = 600,
  parameter int unsigned DAT_SU_NS     = 100,
  parameter int unsigned STO_SU_NS     = 600
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 clr_i,
  output logic                 scl_o,
  output logic                 sda_o,
  output logic                 start_o,
  output logic                 stop_o,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 evt_o,
  output logic [2:0]           evt_code_o
);
  localparam int unsigned FILT_CYC = (SPIKE_NS * 1000) / CLK_PERIOD_PS + 1;

  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    i2c_tmon_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[l]),
      .line_o(filt_lines[l])
    );
  end

  assign scl_o = filt_lines[0];
  assign sda_o = filt_lines[1];

  logic scl_rise, scl_fall, sda_edge;

  i2c_tmon_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_o),
    .sda_i     (sda_o),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .sda_edge_o(sda_edge),
    .start_o   (start_o),
    .stop_o    (stop_o)
  );

  i2c_tmon_check #(
    .LOW_CYC   (ns_to_cyc(LOW_NS, CLK_PERIOD_PS)),
    .HIGH_CYC  (ns_to_cyc(HIGH_NS, CLK_PERIOD_PS)),
    .BUF_CYC   (ns_to_cyc(BUF_NS, CLK_PERIOD_PS)),
    .STA_SU_CYC(ns_to_cyc(STA_SU_NS, CLK_PERIOD_PS)),
    .STA_HD_CYC(ns_to_cyc(STA_HD_NS, CLK_PERIOD_PS)),
    .DAT_SU_CYC(ns_to_cyc(DAT_SU_NS, CLK_PERIOD_PS)),
    .STO_SU_CYC(ns_to_cyc(STO_SU_NS, CLK_PERIOD_PS))
  ) u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_edge_i(sda_edge),
    .start_i   (start_o),
    .stop_i    (stop_o),
    .clr_i     (clr_i),
    .viol_o    (viol_o),
    .evt_o     (evt_o),
    .evt_code_o(evt_code_o)
  );

  AST_START_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (scl_o && !sda_o)); // R2
  AST_STOP_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (scl_o && sda_o)); // R3
  AST_START_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_STOP_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o); // R3
endmodule

// File: tb/i2c_timing_monitor_tb_top.sv
module i2c_timing_monitor_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       clr_i = 1'b0;
  logic       scl_o, sda_o, start_o, stop_o, evt_o;
  logic [6:0] viol_o;
  logic [2:0] evt_code_o;

  always #10 clk_i = ~clk_i;

  i2c_timing_monitor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .clr_i(clr_i),
    .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .stop_o(stop_o),
    .viol_o(viol_o), .evt_o(evt_o), .evt_code_o(evt_code_o)
  );

  int         n_tests = 0;
  int         n_fail  = 0;
  int         n_start = 0;
  int         n_stop  = 0;
  bit         done    = 1'b0;
  logic [2:0] exp_q[$];

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (start_o) n_start++;
      if (stop_o)  n_stop++;
      if (evt_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12 unexpected event", int'(evt_code_o), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check(evt_code_o == e, "R12 event code", int'(evt_code_o), int'(e));
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_code(logic [2:0] c);
    exp_q.push_back(c);
  endtask

  task automatic go_start(int hd);
    sda_i = 1'b0; tick(hd); scl_i = 1'b0;
  endtask

  task automatic send_bit(logic v, int pre, int su, int hi);
    tick(pre); sda_i = v; tick(su); scl_i = 1'b1; tick(hi); scl_i = 1'b0;
  endtask

  task automatic go_stop(int pre, int su, int hi);
    tick(pre); sda_i = 1'b0; tick(su); scl_i = 1'b1; tick(hi); sda_i = 1'b1;
  endtask

  task automatic clean_tail();
    send_bit(1'b0, 10, 60, 35);
    go_stop(10, 60, 35);
    tick(80);
  endtask

  task automatic check_mask(logic [6:0] m, string req);
    tick(12);
    check(viol_o == m, req, int'(viol_o), int'(m));
    check(exp_q.size() == 0, {req, " pending events"}, exp_q.size(), 0);
  endtask

  task automatic do_clear();
    clr_i = 1'b1; tick(1); clr_i = 1'b0; tick(1);
    check(viol_o == 7'd0, "R11 clear", int'(viol_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, p0;
    bit seen_low;
    tick(5);
    check(scl_o == 1'b1 && sda_o == 1'b1, "R1 reset lines", {scl_o, sda_o}, 3);
    check(viol_o == 7'd0 && evt_o == 1'b0, "R11 reset viol", int'(viol_o), 0);
    rst_ni = 1'b1;
    tick(10);

    // clean frame, R2 R3
    s0 = n_start; p0 = n_stop;
    go_start(40);
    send_bit(1'b1, 10, 60, 35);
    send_bit(1'b0, 10, 60, 35);
    send_bit(1'b1, 10, 60, 35);
    go_stop(10, 60, 35);
    tick(80);
    check(n_start == s0 + 1, "R2 start count", n_start - s0, 1);
    check(n_stop == p0 + 1, "R3 stop count", n_stop - p0, 1);
    check_mask(7'd0, "R4 clean frame");

    // R4 short low
    expect_code(3'd0);
    go_start(40); send_bit(1'b1, 10, 30, 35); clean_tail();
    check_mask(7'b0000001, "R4 low");
    do_clear();

    // R5 short high
    expect_code(3'd1);
    go_start(40); send_bit(1'b1, 10, 60, 20); clean_tail();
    check_mask(7'b0000010, "R5 high");
    do_clear();

    // R5 boundary: 30 passes, 29 fails
    expect_code(3'd1);
    go_start(40); send_bit(1'b1, 10, 60, 30); send_bit(1'b0, 10, 60, 29); clean_tail();
    check_mask(7'b0000010, "R5 boundary");
    do_clear();

    // R9 short data setup
    expect_code(3'd5);
    go_start(40); send_bit(1'b1, 10, 60, 35); send_bit(1'b0, 63, 2, 35); clean_tail();
    check_mask(7'b0100000, "R9 data setup");
    do_clear();

    // R10 short stop setup
    expect_code(3'd6);
    go_start(40); send_bit(1'b1, 10, 60, 35); go_stop(10, 60, 10); tick(80);
    check_mask(7'b1000000, "R10 stop setup");
    do_clear();

    // R6 short bus free
    expect_code(3'd2);
    go_start(40); send_bit(1'b1, 10, 60, 35); go_stop(10, 60, 35);
    tick(20);
    go_start(40); clean_tail();
    check_mask(7'b0000100, "R6 bus free");
    do_clear();

    // R7 repeated start with short setup
    expect_code(3'd3);
    go_start(40); send_bit(1'b0, 10, 60, 35);
    tick(10); sda_i = 1'b1; tick(60); scl_i = 1'b1; tick(10); sda_i = 1'b0; tick(40); scl_i = 1'b0;
    clean_tail();
    check_mask(7'b0001000, "R7 start setup");
    do_clear();

    // R8 short start hold
    expect_code(3'd4);
    go_start(10); send_bit(1'b1, 10, 60, 35); clean_tail();
    check_mask(7'b0010000, "R8 start hold");
    do_clear();

    // R11 sticky accumulation across two events
    expect_code(3'd1);
    expect_code(3'd6);
    go_start(40); send_bit(1'b1, 10, 60, 20); go_stop(10, 60, 10); tick(80);
    check_mask(7'b1000010, "R11 sticky");
    do_clear();

    // R1 spike: 2-cycle SDA glitch ignored
    s0 = n_start;
    seen_low = 1'b0;
    sda_i = 1'b0; tick(2); sda_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!sda_o) seen_low = 1'b1;
    end
    check(!seen_low, "R1 sda spike", int'(seen_low), 0);
    check(n_start == s0, "R1 spike no start", n_start - s0, 0);

    // R1 SCL glitch ignored
    seen_low = 1'b0;
    scl_i = 1'b0; tick(2); scl_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!scl_o) seen_low = 1'b1;
    end
    check(!seen_low, "R1 scl spike", int'(seen_low), 0);

    // R1 3-cycle pulse accepted: start then stop
    s0 = n_start; p0 = n_stop;
    sda_i = 1'b0; tick(3); sda_i = 1'b1; tick(80);
    check(n_start == s0 + 1 && n_stop == p0 + 1, "R1 pulse accepted",
          n_start - s0 + n_stop - p0, 2);
    check_mask(7'd0, "R1 pulse no violation");

    // R13 long idle then compliant frame
    tick(3000);
    go_start(40); send_bit(1'b1, 10, 60, 35); clean_tail();
    check_mask(7'd0, "R13 saturation");

    // R12 simultaneous rules: short low and short setup on one SCL rise -> code 0
    expect_code(3'd0);
    go_start(40); send_bit(1'b1, 10, 60, 35); send_bit(1'b0, 10, 2, 35); clean_tail();
    check_mask(7'b0100001, "R12 priority");
    do_clear();

    check(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule